// File: doc/BRIEF.md
# Signed-Digit Borrow-Propagate Adder

This block adds two unsigned or two's-complement words without a carry chain. It rewrites the sum as A minus the one's complement of B, minus one, modulo 2^WIDTH. Each bit position first forms a digit in {-1, 0, +1} from its own operand bits. That step needs no information from any other position. A borrow then resolves from the least significant position upward, and the borrow into position 0 is forced to 1 to supply the minus one. Each sum bit is recovered from its digit and the borrow that enters its position.

The digit code is chosen so that the borrow out of each position is one two-input multiplexer. Its select is the digit's R bit, its data-1 input is the incoming borrow, and its data-0 input is the T bit. This gives two ways to resolve the borrows, chosen by a parameter. One is a ripple chain of multiplexers. The other is a logarithmic prefix tree built from the same select-and-merge operator. Sum, top borrow and overflow are registered, so results appear one clock after the operands.

Top module: `sd_borrow_adder`

## Requirements
- R1: One clock edge after operands are presented, sum_o equals (a_i + b_i) mod 2^WIDTH.
- R2: borrow_o is the logical borrow out of the top position, where a logical 1 stands for an algebraic -1. It is 1 exactly when a_i + b_i < 2^WIDTH, that is, when an ordinary adder would give no carry-out.
- R3: ovf_o is the XOR of the borrows into and out of the most significant position. It equals two's-complement overflow of a_i + b_i.
- R4: Each digit y = a - NOT b is coded on (T, R) as -1 -> 10, 0 -> 01, +1 -> 00, and the code 11 never occurs. An all-zero operand pair gives every digit -1, and an all-one pair gives every digit +1. Both cases still produce the correct sum.
- R5: The borrow into position 0 is forced to 1. When every digit is 0 (b_i is the bitwise inverse of a_i), this borrow passes through every position, so borrow_o = 1 and sum_o is all ones. With a_i all ones and b_i = 1, the result is sum_o = 0 and borrow_o = 0.
- R6: The ripple variant (USE_TREE = 0) and the prefix-tree variant (USE_TREE = 1) produce identical sum_o, borrow_o and ovf_o for every operand pair.
- R7: While rst_ni is low, sum_o, borrow_o and ovf_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sum_o | output | WIDTH | Registered sum modulo 2^WIDTH |
| borrow_o | output | 1 | Registered borrow out of the top position (1 = no carry) |
| ovf_o | output | 1 | Registered signed overflow |

## Verification
The hardest case to reach is a borrow that must cross every position. In the tree this is the longest merge path, and it occurs only when every digit is 0, that is, when b_i is exactly the inverse of a_i. Random operands almost never produce this at 32 bits. So a 6-bit build is swept over all 4096 operand pairs, which covers every propagation length and both extreme digit patterns. The ripple and tree builds are compared on every pair. A 32-bit tree build receives random operands together with directed full-propagation pairs.

// File: rtl/sd_add_pkg.sv
package sd_add_pkg;
  // Digit code on {T, R}
  typedef enum logic [1:0] {
    SD_POS  = 2'b00,
    SD_ZERO = 2'b01,
    SD_NEG  = 2'b10
  } sd_digit_e;
endpackage

// File: rtl/sd_digit_enc.sv
module sd_digit_enc
  import sd_add_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] t_o,
  output logic [WIDTH-1:0] r_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pos
    sd_digit_e dig;
    always_comb begin
      unique case ({a_i[i], ~b_i[i]})
        2'b00:   dig = SD_ZERO;
        2'b01:   dig = SD_NEG;
        2'b10:   dig = SD_POS;
        default: dig = SD_ZERO;
      endcase
    end
    assign t_o[i] = dig[1];
    assign r_o[i] = dig[0];

    // R4: code 11 is never produced
    always_comb begin
      if (!$isunknown({t_o[i], r_o[i]}))
        a_r4_no_code_11: assert (!(t_o[i] && r_o[i]));
    end
  end
endmodule

// File: rtl/sd_borrow_net.sv
module sd_borrow_net #(
  parameter int unsigned WIDTH    = 32,
  parameter bit          USE_TREE = 1'b1
) (
  input  logic [WIDTH-1:0] t_i,
  input  logic [WIDTH-1:0] r_i,
  output logic [WIDTH-1:0] borrow_o
);
  localparam int unsigned LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  if (USE_TREE) begin : g_tree
    logic [WIDTH-1:0] lvl_r [LEVELS+1];
    logic [WIDTH-1:0] lvl_t [LEVELS+1];
    assign lvl_r[0] = r_i;
    assign lvl_t[0] = t_i;
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int unsigned DIST = 1 << l;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i >= DIST) begin : g_merge
          assign lvl_r[l+1][i] = lvl_r[l][i] & lvl_r[l][i-DIST];
          assign lvl_t[l+1][i] = lvl_r[l][i] ? lvl_t[l][i-DIST] : lvl_t[l][i];
        end else begin : g_pass
          assign lvl_r[l+1][i] = lvl_r[l][i];
          assign lvl_t[l+1][i] = lvl_t[l][i];
        end
      end
    end
    // Forced borrow-in of 1 selected where the whole span propagates
    assign borrow_o = lvl_r[LEVELS] | lvl_t[LEVELS];
  end else begin : g_ripple
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic prev;
      if (i == 0) begin : g_lsb
        assign prev = 1'b1;
      end else begin : g_up
        assign prev = borrow_o[i-1];
      end
      assign borrow_o[i] = r_i[i] ? prev : t_i[i];
    end
  end

  // R5: all-propagate digits pass the forced borrow to the top
  always_comb begin
    if (!$isunknown(r_i) && (&r_i))
      a_r5_full_propagate: assert (borrow_o[WIDTH-1] == 1'b1);
  end
endmodule

// File: rtl/sd_sum_recover.sv
module sd_sum_recover #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] r_i,
  input  logic [WIDTH-1:0] borrow_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] borrow_in;
  if (WIDTH > 1) begin : g_shift
    assign borrow_in = {borrow_i[WIDTH-2:0], 1'b1};
  end else begin : g_one
    assign borrow_in = 1'b1;
  end
  assign sum_o = ~r_i ^ borrow_in;
endmodule

// File: rtl/sd_borrow_adder.sv
module sd_borrow_adder #(
  parameter int unsigned WIDTH    = 32,  // >= 2
  parameter bit          USE_TREE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             borrow_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] dig_t, dig_r, borrow, sum_d;

  sd_digit_enc #(.WIDTH(WIDTH)) u_enc (
    .a_i(a_i), .b_i(b_i), .t_o(dig_t), .r_o(dig_r)
  );

  sd_borrow_net #(.WIDTH(WIDTH), .USE_TREE(USE_TREE)) u_net (
    .t_i(dig_t), .r_i(dig_r), .borrow_o(borrow)
  );

  sd_sum_recover #(.WIDTH(WIDTH)) u_sum (
    .r_i(dig_r), .borrow_i(borrow), .sum_o(sum_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o    <= '0;
      borrow_o <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      sum_o    <= sum_d;
      borrow_o <= borrow[MSB];
      ovf_o    <= borrow[MSB] ^ borrow[MSB-1];
    end
  end

  a_r1_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> sum_o == WIDTH'($past(a_i) + $past(b_i)));

  // R2: no carry out <-> logical borrow
  a_r2_borrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> borrow_o ==
      !(($past(a_i[MSB]) & $past(b_i[MSB])) |
        (($past(a_i[MSB]) | $past(b_i[MSB])) & !sum_o[MSB])));

  a_r3_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ovf_o ==
      (($past(a_i[MSB]) == $past(b_i[MSB])) && (sum_o[MSB] != $past(a_i[MSB]))));
endmodule

// File: tb/tb_sd_borrow_adder.sv
module tb_sd_borrow_adder;
  localparam int unsigned NS = 6;
  localparam int unsigned NW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NS-1:0] a_s, b_s, sum_t, sum_r;
  logic          bo_t, bo_r, ov_t, ov_r;
  logic [NW-1:0] a_w, b_w, sum_w;
  logic          bo_w, ov_w;

  sd_borrow_adder #(.WIDTH(NS), .USE_TREE(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_s), .b_i(b_s),
    .sum_o(sum_t), .borrow_o(bo_t), .ovf_o(ov_t));
  sd_borrow_adder #(.WIDTH(NS), .USE_TREE(1'b0)) dut_rpl (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_s), .b_i(b_s),
    .sum_o(sum_r), .borrow_o(bo_r), .ovf_o(ov_r));
  sd_borrow_adder #(.WIDTH(NW), .USE_TREE(1'b1)) dut_wide (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_w), .b_i(b_w),
    .sum_o(sum_w), .borrow_o(bo_w), .ovf_o(ov_w));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Checks small builds against a reference sum of the operands driven last cycle
  task automatic chk_small(input logic [NS-1:0] a, input logic [NS-1:0] b, input string pfx);
    logic [NS:0] s;
    bit ov;
    s  = {1'b0, a} + {1'b0, b};
    ov = (a[NS-1] == b[NS-1]) && (s[NS-1] != a[NS-1]);
    chk(sum_t == s[NS-1:0], {pfx, " R1 sum"}, sum_t, s[NS-1:0]);
    chk(bo_t == !s[NS], {pfx, " R2 borrow"}, bo_t, !s[NS]);
    chk(ov_t == ov, {pfx, " R3 ovf"}, ov_t, ov);
    chk({sum_r, bo_r, ov_r} == {sum_t, bo_t, ov_t}, {pfx, " R6 ripple vs tree"},
        {sum_r, bo_r, ov_r}, {sum_t, bo_t, ov_t});
  endtask

  task automatic chk_wide(input logic [NW-1:0] a, input logic [NW-1:0] b, input string pfx);
    logic [NW:0] s;
    bit ov;
    s  = {1'b0, a} + {1'b0, b};
    ov = (a[NW-1] == b[NW-1]) && (s[NW-1] != a[NW-1]);
    chk(sum_w == s[NW-1:0], {pfx, " R1 wide sum"}, sum_w, s[NW-1:0]);
    chk(bo_w == !s[NW], {pfx, " R2 wide borrow"}, bo_w, !s[NW]);
    chk(ov_w == ov, {pfx, " R3 wide ovf"}, ov_w, ov);
  endtask

  task automatic apply(input logic [NS-1:0] a, input logic [NS-1:0] b,
                       input logic [NW-1:0] aw, input logic [NW-1:0] bw);
    a_s = a; b_s = b; a_w = aw; b_w = bw;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    a_s = '1; b_s = '1; a_w = '1; b_w = '1;
    repeat (3) @(negedge clk);
    // R7: outputs cleared during reset despite nonzero operands
    chk({sum_t, bo_t, ov_t} == '0, "R7 reset small", {sum_t, bo_t, ov_t}, 0);
    chk({sum_r, bo_r, ov_r} == '0, "R7 reset ripple", {sum_r, bo_r, ov_r}, 0);
    chk({sum_w, bo_w, ov_w} == '0, "R7 reset wide", {sum_w, bo_w, ov_w}, 0);
    rst_n = 1'b1;

    for (int ia = 0; ia < (1 << NS); ia++) begin
      for (int ib = 0; ib < (1 << NS); ib++) begin
        logic [NW-1:0] ra, rb;
        ra = $urandom;
        rb = $urandom;
        apply(NS'(ia), NS'(ib), ra, rb);
        chk_small(NS'(ia), NS'(ib), "sweep");
        chk_wide(ra, rb, "rand");
      end
    end

    // R4: all digits -1 and all digits +1
    apply('0, '0, '0, '0);
    chk_small('0, '0, "R4 all-neg");
    chk_wide('0, '0, "R4 all-neg");
    apply('1, '1, '1, '1);
    chk_small('1, '1, "R4 all-pos");
    chk_wide('1, '1, "R4 all-pos");

    // R5: every digit zero, forced borrow crosses all positions
    apply(6'h2A, 6'h15, 32'hA5A5_0F0F, 32'h5A5A_F0F0);
    chk(sum_t == 6'h3F && bo_t == 1'b1, "R5 full propagate small", {sum_t, bo_t}, {6'h3F, 1'b1});
    chk(sum_w == 32'hFFFF_FFFF && bo_w == 1'b1, "R5 full propagate wide",
        {sum_w, bo_w}, {32'hFFFF_FFFF, 1'b1});
    apply('1, 6'd1, '1, 32'd1);
    chk(sum_t == '0 && bo_t == 1'b0, "R5 wrap small", {sum_t, bo_t}, 0);
    chk(sum_w == '0 && bo_w == 1'b0, "R5 wrap wide", {sum_w, bo_w}, 0);
    chk_small('1, 6'd1, "R5 wrap");

    // R7: reset asserted mid-run clears outputs
    rst_n = 1'b0;
    #1;
    chk({sum_w, bo_w, ov_w} == '0, "R7 mid-run reset", {sum_w, bo_w, ov_w}, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule